// File: doc/BRIEF.md
# Serial-Programmed Line Driver Control Register

This block is the digital control section of a programmable-gain line driver. A three-wire, write-only serial port carries one 8-bit control word per frame. The port has an active-low select, a data line and a serial clock. Data bits shift in while the select is low. The word moves into a holding register only when the select returns high, so a partly shifted frame never reaches the controls.

The held word is combined with two hardware pins, a transmit enable and an active-low shutdown. The result drives five control levels: a 6-bit gain code, a high-gain/low-noise select, a transmit-active flag, an analog-enable flag and a full power-down flag. The serial side runs on the serial clock and the select edge. The outputs are produced in the system clock domain, behind a two-flop synchroniser.

Top module: `linedrv_ctrl`

## Requirements
- R1: While `cs_n` is low, each rising `sclk` edge shifts `sdata` in, most significant bit first. The outputs do not change until `cs_n` rises.
- R2: If a frame has other than 8 clock edges, the 8 most recently shifted bits are held. With fewer than 8 edges, the bits left over from the previous frame fill the upper positions.
- R3: With `shdn_n` high, `gain_code` equals bits 5..0 of the held word.
- R4: `tx_active` is 1 exactly when `shdn_n` is high, `tx_en` is high and held bit 7 is 1.
- R5: `hi_gain` is 1 exactly when `tx_active` is 1 and held bit 6 is 1. A 0 in bit 6 selects the low-noise stage.
- R6: Held bits 7..6 = 00 is a software off state. `analog_en`, `tx_active` and `hi_gain` are 0, and `gain_code` still shows the held gain bits.
- R7: Held bits 7..6 not equal to 00, together with `tx_active` = 0, is the isolation state: `analog_en` = 1 and `tx_active` = 0.
- R8: While `shdn_n` is low, `power_down` = 1 and every other output is 0. The shift register and holding register are cleared and serial frames are ignored. After release, the held word is all zeros.
- R9: During `rst_n` low, `power_down` = 1 and the other outputs are 0. A change on any input reaches the outputs on the second rising `clk` edge after it and not on the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the output synchroniser |
| rst_n | input | 1 | Active-low reset; clears the synchroniser and the held word |
| cs_n | input | 1 | Active-low frame select; its rising edge loads the held word |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdata | input | 1 | Serial data, MSB first |
| tx_en | input | 1 | Hardware transmit enable |
| shdn_n | input | 1 | Active-low hardware shutdown |
| gain_code | output | 6 | Gain step code |
| hi_gain | output | 1 | 1 = high-gain output stage, 0 = low-noise stage |
| tx_active | output | 1 | Transmit path active |
| analog_en | output | 1 | Analog circuitry powered |
| power_down | output | 1 | Full hardware power-down in effect |

## Verification
The hardest condition to reach from the ports is a frame whose length is not 8 bits. The held result then depends on bits left behind by the previous frame. To reach it, the stimulus first loads a known full word. It then sends a 3-bit frame and a 10-bit frame, and compares each result with a shift-register model kept in the bench.

A second hard case is a frame sent while `shdn_n` is low. The stimulus sends one, releases shutdown, and checks that the held word reads back as all zeros and not as the ignored frame.

// File: rtl/linedrv_ctrl.sv
`timescale 1ns/1ps
module linedrv_ctrl #(
  parameter int GAIN_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              tx_en,
  input  logic              shdn_n,
  output logic [GAIN_W-1:0] gain_code,
  output logic              hi_gain,
  output logic              tx_active,
  output logic              analog_en,
  output logic              power_down
);
  localparam int WORD_W = GAIN_W + 2;
  localparam int SYNC_W = WORD_W + 2;

  logic              clr_n;
  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] held_q;
  logic [SYNC_W-1:0] sync_q [SYNC_STAGES];
  logic [SYNC_W-1:0] sync_in;
  logic [WORD_W-1:0] w;
  logic              te, sd;

  assign clr_n = shdn_n & rst_n;

  always_ff @(posedge sclk or negedge clr_n)
    if (!clr_n)     shift_q <= '0;
    else if (!cs_n) shift_q <= {shift_q[WORD_W-2:0], sdata};

  always_ff @(posedge cs_n or negedge clr_n)
    if (!clr_n) held_q <= '0;
    else        held_q <= shift_q;

  assign sync_in = {shdn_n, tx_en, held_q};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= sync_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end

  assign {sd, te, w} = sync_q[SYNC_STAGES-1];

  assign power_down = ~sd;
  assign gain_code  = sd ? w[GAIN_W-1:0] : '0;
  assign analog_en  = sd & (w[WORD_W-1] | w[WORD_W-2]);
  assign tx_active  = sd & te & w[WORD_W-1];
  assign hi_gain    = tx_active & w[WORD_W-2];
endmodule

module linedrv_ctrl_chk #(
  parameter int GAIN_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic [GAIN_W-1:0] gain_code,
  input logic              hi_gain,
  input logic              tx_active,
  input logic              analog_en,
  input logic              power_down
);
  p_pd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> (!analog_en && !tx_active && !hi_gain && gain_code == '0));

  p_tx_powered_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |-> analog_en);

  p_hg_only_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hi_gain |-> tx_active);

  p_pd_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({power_down, analog_en}));

  p_tx_pin_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |-> $past(tx_en, 2));
endmodule

bind linedrv_ctrl linedrv_ctrl_chk #(.GAIN_W(GAIN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .gain_code(gain_code),
  .hi_gain(hi_gain), .tx_active(tx_active), .analog_en(analog_en),
  .power_down(power_down)
);

// File: tb/linedrv_ctrl_tb_top.sv
`timescale 1ns/1ps
module linedrv_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, sdata, tx_en, shdn_n;
  logic [5:0] gain_code;
  logic hi_gain, tx_active, analog_en, power_down;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m_sh, m_lat;
  logic       m_sd, m_te;

  always #2.5 clk = ~clk;

  linedrv_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdata(sdata),
    .tx_en(tx_en), .shdn_n(shdn_n), .gain_code(gain_code), .hi_gain(hi_gain),
    .tx_active(tx_active), .analog_en(analog_en), .power_down(power_down)
  );

  // {tx_en, word, power_down, analog_en, tx_active, hi_gain, gain}
  localparam logic [18:0] VEC [0:7] = '{
    {1'b1, 8'hFD, 4'b0111, 6'h3D},
    {1'b1, 8'h8D, 4'b0110, 6'h0D},
    {1'b0, 8'hC5, 4'b0100, 6'h05},
    {1'b1, 8'h6A, 4'b0100, 6'h2A},
    {1'b1, 8'h3F, 4'b0000, 6'h3F},
    {1'b1, 8'h00, 4'b0000, 6'h00},
    {1'b0, 8'h80, 4'b0100, 6'h00},
    {1'b1, 8'hC0, 4'b0111, 6'h00}
  };

  function automatic logic [9:0] model_out(input logic sd, input logic te, input logic [7:0] w);
    logic tx;
    if (!sd) return {1'b1, 9'b0};
    tx = te & w[7];
    return {1'b0, w[7] | w[6], tx, tx & w[6], w[5:0]};
  endfunction

  task automatic compare(input string req, input logic [9:0] exp);
    logic [9:0] act;
    act = {power_down, analog_en, tx_active, hi_gain, gain_code};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_model(input string req);
    compare(req, model_out(m_sd, m_te, m_lat));
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [15:0] bits, input int n);
    cs_n = 1'b0;
    #30;
    for (int i = 0; i < n; i++) begin
      sdata = bits[n-1-i];
      #30;
      sclk = 1'b1;
      if (m_sd) m_sh = {m_sh[6:0], sdata};
      #60;
      sclk = 1'b0;
      #30;
    end
  endtask

  task automatic end_frame;
    #30;
    cs_n = 1'b1;
    if (m_sd) m_lat = m_sh;
    #30;
    wait_clk(4);
  endtask

  task automatic write_word(input logic [15:0] bits, input int n);
    shift_bits(bits, n);
    end_frame();
  endtask

  initial begin
    wait_clk(150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdata = 1'b0;
    tx_en = 1'b0; shdn_n = 1'b0;
    m_sh = '0; m_lat = '0; m_sd = 1'b0; m_te = 1'b0;
    wait_clk(3);
    compare("R9 reset state", {1'b1, 9'b0});

    rst_n = 1'b1;
    shdn_n = 1'b1; m_sd = 1'b1;
    wait_clk(4);
    compare("R8 zero word after release", 10'b0);

    for (int i = 0; i < 8; i++) begin
      tx_en = VEC[i][18]; m_te = VEC[i][18];
      write_word({8'h00, VEC[i][17:10]}, 8);
      compare("R3 R4 R5 R6 R7 table", VEC[i][9:0]);
      check_model("R3 model cross-check");
    end

    shift_bits(16'h000D, 8);
    wait_clk(4);
    check_model("R1 no change before select rise");
    compare("R1 still old word", {4'b0111, 6'h00});
    end_frame();
    check_model("R1 word after select rise");

    write_word(16'h00FD, 8);
    write_word(16'h0005, 3);
    compare("R2 short frame", {4'b0111, 6'h2D});
    write_word(16'h0385, 10);
    compare("R2 long frame", {4'b0110, 6'h05});

    tx_en = 1'b0; m_te = 1'b0;
    @(negedge clk);
    compare("R9 one edge later unchanged", {4'b0110, 6'h05});
    @(negedge clk);
    compare("R9 two edges later updated", {4'b0100, 6'h05});

    tx_en = 1'b1; m_te = 1'b1;
    write_word(16'h00FD, 8);
    check_model("R5 high gain before shutdown");
    shdn_n = 1'b0; m_sd = 1'b0; m_sh = '0; m_lat = '0;
    wait_clk(4);
    compare("R8 shutdown outputs", {1'b1, 9'b0});
    write_word(16'h00C7, 8);
    compare("R8 frame ignored in shutdown", {1'b1, 9'b0});
    shdn_n = 1'b1; m_sd = 1'b1;
    wait_clk(4);
    compare("R8 held word cleared", 10'b0);
    check_model("R6 cleared word is off state");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule